// File: doc/BRIEF.md
# SDRAM Power-Up Initialisation Sequencer

This block brings a single-rank SDRAM from power-up into normal service and then keeps it refreshed. After reset is released it holds the command bus at NOP for a programmable settling time. It then issues a fixed bring-up program: close all banks, load the mode register, run eight auto-refresh cycles, and load the mode register a second time. The second load covers devices that only accept the mode after the refresh cycles.

Once the second mode load has gone out, a refresh timer starts. Each time it expires, the block raises a one-cycle refresh request and issues a group of four auto-refresh commands. While the timer runs, the sequencer also issues ten warm-up reads. After the tenth read it declares the memory ready. From then on it issues only refresh groups.

The refresh interval comes from a prescaler followed by a period counter. A slow-refresh select doubles the prescale ratio, which halves the refresh rate for low-density parts. The data path and the scheduling of normal accesses sit outside this block.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, and for the first two clocks after it is released, the outputs are cmd_o = NOP, addr_o = 0, init_done_o = 0 and ref_req_o = 0. The reset takes effect without waiting for a clock edge.
- R2: Commands are encoded as {cs_n, ras_n, cas_n, we_n}:
  - NOP = 4'b0111
  - PRECHARGE ALL = 4'b0010
  - AUTO REFRESH = 4'b0001
  - MODE REGISTER SET = 4'b0000
  - READ = 4'b0101

  During the first WAIT_CYC active clocks, only NOP appears.
- R3: The bring-up program is issued in this order: PRECHARGE ALL (addr_o has bit AP_BIT set and all other bits 0), then MODE REGISTER SET, then eight AUTO REFRESH commands with addr_o = 0, then MODE REGISTER SET. The first command appears on active clock WAIT_CYC+1.
- R4: Both mode register loads drive addr_o = MODE_VAL shifted left by WORD_SHIFT. With the defaults, MODE_VAL = 0x22 (CAS latency 2, sequential burst of 4, burst writes) and addr_o = 0x088.
- R5: Any two non-NOP commands are separated by at least NOP_GAP NOP cycles. When a command is ready, it is issued exactly NOP_GAP+1 clocks after the previous one.
- R6: No refresh request is raised before the second mode load. With slow_ref_i low, the first ref_req_o pulse comes REF_PERIOD*PRESCALE clocks after the second mode load, and the pulses repeat at that interval. Each pulse lasts one clock.
- R7: With slow_ref_i high, the refresh interval is REF_PERIOD*2*PRESCALE clocks.
- R8: Each refresh request is followed by exactly four AUTO REFRESH commands with addr_o = 0. The first comes one clock after the request if the spacing rule allows. Pending refresh commands take precedence over warm-up reads.
- R9: After the second mode load, ten READ commands are issued, the k-th (counting from 0) with addr_o = k*4. init_done_o rises with the tenth read and stays high.
- R10: Once init_done_o is high, the only commands issued are NOP and AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| slow_ref_i | input | 1 | High selects the halved refresh rate |
| cmd_o | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| addr_o | output | ADDR_W | Address lines for precharge-all, mode value and warm-up reads |
| init_done_o | output | 1 | Memory ready; sticky until reset |
| ref_req_o | output | 1 | One-cycle strobe when a refresh group is due |

## Verification
The assertions assume that slow_ref_i is held steady between resets, so the prescale ratio never changes in the middle of a count. They also assume the refresh interval is long enough for a four-command group to finish before the next expiry, which is what bounds the pending-refresh count. The stimulus changes the slow select only while reset is asserted. It uses a short period that still exceeds the length of a group, yet is shorter than the warm-up phase, so refresh groups interleave with the warm-up reads. One reset is applied in the middle of operation to check the asynchronous return to the idle outputs.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  // Command encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_READ = 4'b0101,
    CMD_NOP  = 4'b0111
  } sdi_cmd_e;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_INIT = 2'd1,
    PH_WARM = 2'd2,
    PH_RUN  = 2'd3
  } sdi_phase_e;

endpackage

// File: rtl/sdi_rst_sync.sv
module sdi_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/sdi_refresh_timer.sv
module sdi_refresh_timer #(
  parameter int PRESCALE   = 8,
  parameter int REF_PERIOD = 195
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic slow_i,
  output logic en_o,
  output logic expire_o
);
  localparam int PSW = $clog2(2*PRESCALE);
  localparam int PDW = $clog2(REF_PERIOD+1);

  logic           en_q, en_d;
  logic [PSW-1:0] pre_q, pre_d, pre_last;
  logic [PDW-1:0] per_q, per_d;
  logic           tick;

  assign pre_last = slow_i ? PSW'(2*PRESCALE-1) : PSW'(PRESCALE-1);
  assign tick     = en_q && (pre_q >= pre_last);
  assign expire_o = tick && (per_q == PDW'(1));
  assign en_o     = en_q;

  always_comb begin
    en_d  = en_q;
    pre_d = pre_q;
    per_d = per_q;
    if (start_i) begin
      en_d  = 1'b1;
      pre_d = '0;
      per_d = PDW'(REF_PERIOD);
    end else if (en_q) begin
      pre_d = tick ? '0 : pre_q + PSW'(1);
      if (tick) per_d = (per_q == PDW'(1)) ? PDW'(REF_PERIOD) : per_q - PDW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pre_q <= '0;
      per_q <= '0;
    end else begin
      en_q <= en_d;
      if (start_i || en_q) begin
        pre_q <= pre_d;
        per_q <= per_d;
      end
    end
  end
endmodule

// File: rtl/sdi_refresh_pend.sv
module sdi_refresh_pend #(
  parameter int REF_BURST = 4,
  parameter int PEND_W    = $clog2(2*REF_BURST+1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              expire_i,
  input  logic              take_i,
  output logic              req_o,
  output logic              busy_o,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              req_q;

  always_comb begin
    pend_d = pend_q;
    if (take_i)   pend_d = pend_d - PEND_W'(1);
    if (expire_i) pend_d = pend_d + PEND_W'(REF_BURST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      req_q  <= 1'b0;
    end else begin
      req_q <= expire_i;
      if (take_i || expire_i) pend_q <= pend_d;
    end
  end

  assign req_o  = req_q;
  assign busy_o = (pend_q != '0);
  assign pend_o = pend_q;
endmodule

// File: rtl/sdi_seq_ctrl.sv
module sdi_seq_ctrl
  import sdi_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          WAIT_CYC   = 10000,
  parameter int          NOP_GAP    = 2,
  parameter int          INIT_AREF  = 8,
  parameter int          WARM_COUNT = 10,
  parameter int          AP_BIT     = 10,
  parameter int          WORD_SHIFT = 2,
  parameter logic [7:0]  MODE_VAL   = 8'h22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_busy_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              take_o,
  output logic              tmr_start_o
);
  localparam int INIT_STEPS = INIT_AREF + 3;
  localparam int LAST_INIT  = INIT_STEPS - 1;
  localparam int STEP_MAX   = (INIT_STEPS > WARM_COUNT) ? INIT_STEPS : WARM_COUNT;
  localparam int SW         = $clog2(STEP_MAX + 1);
  localparam int WCW        = $clog2(WAIT_CYC + 1);
  localparam int GW         = $clog2(NOP_GAP + 1);
  localparam logic [ADDR_W-1:0] PRE_ADDR  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_VAL) << WORD_SHIFT;

  sdi_phase_e        phase_q, phase_d;
  logic [WCW-1:0]    wcnt_q, wcnt_d;
  logic [SW-1:0]     step_q, step_d;
  logic [GW-1:0]     gap_q, gap_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              issue_ok;

  assign issue_ok = (gap_q == '0);

  always_comb begin
    phase_d     = phase_q;
    wcnt_d      = wcnt_q;
    step_d      = step_q;
    gap_d       = issue_ok ? gap_q : gap_q - GW'(1);
    cmd_d       = CMD_NOP;
    addr_d      = '0;
    done_d      = done_q;
    take_o      = 1'b0;
    tmr_start_o = 1'b0;
    unique case (phase_q)
      PH_WAIT: begin
        if (wcnt_q == WCW'(WAIT_CYC-1)) begin
          phase_d = PH_INIT;
          step_d  = '0;
        end else begin
          wcnt_d = wcnt_q + WCW'(1);
        end
      end
      PH_INIT: begin
        if (issue_ok) begin
          gap_d = GW'(NOP_GAP);
          if (step_q == '0) begin
            cmd_d  = CMD_PRE;
            addr_d = PRE_ADDR;
          end else if (step_q == SW'(1) || step_q == SW'(LAST_INIT)) begin
            cmd_d  = CMD_MRS;
            addr_d = MODE_ADDR;
          end else begin
            cmd_d  = CMD_AREF;
          end
          if (step_q == SW'(LAST_INIT)) begin
            phase_d     = PH_WARM;
            step_d      = '0;
            tmr_start_o = 1'b1;
          end else begin
            step_d = step_q + SW'(1);
          end
        end
      end
      PH_WARM: begin
        if (issue_ok) begin
          gap_d = GW'(NOP_GAP);
          if (ref_busy_i) begin
            cmd_d  = CMD_AREF;
            take_o = 1'b1;
          end else begin
            cmd_d  = CMD_READ;
            addr_d = ADDR_W'(step_q) << WORD_SHIFT;
            if (step_q == SW'(WARM_COUNT-1)) begin
              phase_d = PH_RUN;
              done_d  = 1'b1;
            end else begin
              step_d = step_q + SW'(1);
            end
          end
        end
      end
      PH_RUN: begin
        if (issue_ok && ref_busy_i) begin
          gap_d  = GW'(NOP_GAP);
          cmd_d  = CMD_AREF;
          take_o = 1'b1;
        end
      end
      default: phase_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_WAIT;
      wcnt_q  <= '0;
      step_q  <= '0;
      gap_q   <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (phase_q == PH_WAIT) wcnt_q <= wcnt_d;
      step_q  <= step_d;
      gap_q   <= gap_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  assign cmd_o  = cmd_q;
  assign addr_o = addr_q;
  assign done_o = done_q;
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int          ADDR_W     = 13,
  parameter int          WAIT_CYC   = 10000,
  parameter int          NOP_GAP    = 2,
  parameter int          INIT_AREF  = 8,
  parameter int          WARM_COUNT = 10,
  parameter int          REF_BURST  = 4,
  parameter int          PRESCALE   = 8,
  parameter int          REF_PERIOD = 195,
  parameter int          AP_BIT     = 10,
  parameter int          WORD_SHIFT = 2,
  parameter logic [7:0]  MODE_VAL   = 8'h22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_ref_i,
  output logic [3:0]        cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done_o,
  output logic              ref_req_o
);
  localparam int PEND_W = $clog2(2*REF_BURST+1);

  logic              rst_sync_n;
  logic              tmr_start, tmr_en, expire;
  logic              take, ref_busy;
  logic [PEND_W-1:0] ref_pend;

  sdi_rst_sync u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  sdi_refresh_timer #(.PRESCALE(PRESCALE), .REF_PERIOD(REF_PERIOD)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .start_i  (tmr_start),
    .slow_i   (slow_ref_i),
    .en_o     (tmr_en),
    .expire_o (expire)
  );

  sdi_refresh_pend #(.REF_BURST(REF_BURST), .PEND_W(PEND_W)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .expire_i (expire),
    .take_i   (take),
    .req_o    (ref_req_o),
    .busy_o   (ref_busy),
    .pend_o   (ref_pend)
  );

  sdi_seq_ctrl #(
    .ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC), .NOP_GAP(NOP_GAP),
    .INIT_AREF(INIT_AREF), .WARM_COUNT(WARM_COUNT), .AP_BIT(AP_BIT),
    .WORD_SHIFT(WORD_SHIFT), .MODE_VAL(MODE_VAL)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .ref_busy_i  (ref_busy),
    .cmd_o       (cmd_o),
    .addr_o      (addr_o),
    .done_o      (init_done_o),
    .take_o      (take),
    .tmr_start_o (tmr_start)
  );
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int WAIT_CYC  = 10000,
  parameter int NOP_GAP   = 2,
  parameter int REF_BURST = 4,
  parameter int PNW       = 4
) (
  input logic           clk_i,
  input logic           rst_n,
  input logic [3:0]     cmd,
  input logic           done,
  input logic           req,
  input logic [PNW-1:0] pend,
  input logic           tmr_en
);
  localparam int CW = $clog2(WAIT_CYC + 2);
  localparam int GW = $clog2(NOP_GAP + 1);
  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] AREF = 4'b0001;

  logic [CW-1:0] cyc_q;
  logic [GW-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= '0;
      quiet_q <= GW'(NOP_GAP);
    end else begin
      if (cyc_q != CW'(WAIT_CYC + 1)) cyc_q <= cyc_q + CW'(1);
      if (cmd != NOP)                 quiet_q <= '0;
      else if (quiet_q != GW'(NOP_GAP)) quiet_q <= quiet_q + GW'(1);
    end
  end

  a_r2_quiet_wait: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cyc_q <= CW'(WAIT_CYC)) |-> (cmd == NOP));

  a_r5_nop_spacing: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cmd != NOP) |-> (quiet_q == GW'(NOP_GAP)));

  a_r6_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_n)
    req |=> !req);

  a_r6_no_req_before_timer: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tmr_en |-> !req);

  a_r8_pend_bounded: assert property (@(posedge clk_i) disable iff (!rst_n)
    pend <= PNW'(REF_BURST));

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    done |=> done);

  a_r10_run_cmds: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(done) |-> (cmd == NOP || cmd == AREF));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .WAIT_CYC(WAIT_CYC), .NOP_GAP(NOP_GAP), .REF_BURST(REF_BURST), .PNW(PEND_W)
) chk_i (
  .clk_i  (clk_i),
  .rst_n  (rst_sync_n),
  .cmd    (cmd_o),
  .done   (init_done_o),
  .req    (ref_req_o),
  .pend   (ref_pend),
  .tmr_en (tmr_en)
);

// File: tb/sdram_init_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_init_seq_tb_top;
  localparam int AW = 13;
  localparam int W  = 20;
  localparam int G  = 2;
  localparam int P  = 3;
  localparam int PS = 8;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, AREF = 4'b0001,
                         MRS = 4'b0000, READ = 4'b0101;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          slow  = 1'b0;
  logic [3:0]    cmd;
  logic [AW-1:0] addr;
  logic          done, req;

  sdram_init_seq #(.ADDR_W(AW), .WAIT_CYC(W), .NOP_GAP(G), .PRESCALE(PS),
                   .REF_PERIOD(P)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .slow_ref_i(slow),
    .cmd_o(cmd), .addr_o(addr), .init_done_o(done), .ref_req_o(req)
  );

  int checks = 0, fails = 0;
  bit finished = 0, cmp_en = 0;

  // ---------------- behavioural reference model ----------------
  logic [3:0]    iq_cmd[$];
  logic [AW-1:0] iq_addr[$];
  int sync_s, n_act, gap_m, ref_m, warm_m, tcnt;
  bit tmr_on, done_m, exp_req;
  logic [3:0]    exp_cmd = NOP;
  logic [AW-1:0] exp_addr = '0;
  string tag = "R1";

  task automatic model_reset();
    iq_cmd.delete(); iq_addr.delete();
    iq_cmd.push_back(PRE);  iq_addr.push_back(AW'(1) << 10);
    iq_cmd.push_back(MRS);  iq_addr.push_back(AW'(8'h22) << 2);
    for (int i = 0; i < 8; i++) begin
      iq_cmd.push_back(AREF); iq_addr.push_back('0);
    end
    iq_cmd.push_back(MRS);  iq_addr.push_back(AW'(8'h22) << 2);
    sync_s = 0; n_act = 0; gap_m = 0; ref_m = 0; warm_m = 0; tcnt = 0;
    tmr_on = 0; done_m = 0; exp_req = 0; exp_cmd = NOP; exp_addr = '0;
    tag = "R1";
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else if (sync_s < 2) sync_s++;
    else begin
      n_act++;
      exp_req = 0; exp_cmd = NOP; exp_addr = '0;
      tag = "R5";
      if (tmr_on) begin
        tcnt++;
        if (tcnt == P * (slow ? 2*PS : PS)) begin
          exp_req = 1; tcnt = 0; tag = slow ? "R7" : "R6";
        end
      end
      if (n_act <= W) tag = "R2";
      else if (gap_m > 0) gap_m--;
      else if (iq_cmd.size() > 0) begin
        exp_cmd = iq_cmd.pop_front(); exp_addr = iq_addr.pop_front(); gap_m = G;
        tag = (exp_cmd == MRS) ? "R4" : "R3";
        if (iq_cmd.size() == 0) begin tmr_on = 1; tcnt = 0; end
      end else if (ref_m > 0) begin
        exp_cmd = AREF; ref_m--; gap_m = G; tag = "R8";
      end else if (warm_m < 10) begin
        exp_cmd = READ; exp_addr = AW'(warm_m * 4); warm_m++; gap_m = G; tag = "R9";
        if (warm_m == 10) done_m = 1;
      end else if (done_m && !exp_req) tag = "R10";
      if (exp_req) ref_m += 4;
    end
  end

  // ---------------- per-cycle comparison and observers ----------------
  int obs_t, mrs_seen, mrs2_t, req1_t, reads_seen, grp_cnt;
  int grp_q[$];
  bit done_seen, in_grp, bad_after_done;

  task automatic obs_reset();
    obs_t = 0; mrs_seen = 0; mrs2_t = -1; req1_t = -1; reads_seen = 0;
    grp_cnt = 0; grp_q.delete(); done_seen = 0; in_grp = 0; bad_after_done = 0;
  endtask

  task automatic check(bit ok, string t, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      checks++;
      if (cmd !== exp_cmd || addr !== exp_addr || done !== done_m || req !== exp_req) begin
        fails++;
        $display("FAIL %s t=%0t: actual cmd=%b addr=%h done=%b req=%b expected cmd=%b addr=%h done=%b req=%b",
                 tag, $time, cmd, addr, done, req, exp_cmd, exp_addr, done_m, exp_req);
      end
      if (rst_n) begin
        obs_t++;
        if (cmd == MRS) begin
          mrs_seen++;
          if (mrs_seen == 2) mrs2_t = obs_t;
        end
        if (req) begin
          if (req1_t < 0) req1_t = obs_t;
          if (in_grp) grp_q.push_back(grp_cnt);
          in_grp = 1; grp_cnt = 0;
        end
        if (cmd == AREF && in_grp) grp_cnt++;
        if (done_seen && (cmd == PRE || cmd == MRS || cmd == READ)) bad_after_done = 1;
        if (cmd == READ) reads_seen++;
        if (done) done_seen = 1;
      end
    end
  end

  task automatic run(bit s, int cycles, bit mid_reset);
    #1 rst_n = 1'b0; slow = s;
    obs_reset();
    repeat (3) @(negedge clk);
    #1;
    check(cmd == NOP && addr == '0 && !done && !req, "R1", "outputs in reset",
          int'({cmd, 1'b0, done, req}), int'({NOP, 1'b0, 1'b0, 1'b0}));
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
    check(req1_t - mrs2_t == P * (s ? 2*PS : PS), s ? "R7" : "R6",
          "first request delay after second mode load", req1_t - mrs2_t,
          P * (s ? 2*PS : PS));
    check(grp_q.size() >= 2, "R8", "complete refresh groups seen", grp_q.size(), 2);
    foreach (grp_q[i]) check(grp_q[i] == 4, "R8", "refresh commands per request", grp_q[i], 4);
    check(done_seen && reads_seen == 10, "R9", "warm-up reads before ready", reads_seen, 10);
    check(!bad_after_done, "R10", "illegal command after ready", int'(bad_after_done), 0);
    if (mid_reset) begin
      #1 rst_n = 1'b0;
      #1 check(cmd == NOP && !done && !req, "R1", "asynchronous reset mid-run",
               int'({cmd, done, req}), int'({NOP, 1'b0, 1'b0}));
    end
  endtask

  initial begin
    model_reset();
    obs_reset();
    cmp_en = 1;
    run(1'b0, 300, 1'b1);
    run(1'b1, 500, 1'b0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule